// File: doc/BRIEF.md
# Sequential Extended Multiply/Divide Unit

This unit does the wide arithmetic of a 16-bit accumulator machine. It handles four operations: a signed single-width divide, an unsigned double-width divide, a signed double-width divide, and a signed single-width multiply. The host register file presents the current D, X and Y values together with an operation code and a one-cycle start strobe. After a fixed number of cycles the unit returns a done strobe. In the same cycle it presents the new D, X and Y values with a write enable for each, and the N, Z, V and C condition flags with a write mask for each.

Internally the operands are reduced to magnitudes. One shared shift register then runs either restoring shift-subtract division or shift-add multiplication, one bit per clock. A final cycle restores the signs, forms the flags and registers the result. The data width `W` is a parameter. The machine width is 16, and the double-width operand is `{Y, D}`.

Top module: `muldiv_unit`

## Requirements
- R1: With op = 0 (signed single-width divide), signed D is divided by signed X. The quotient goes to X and the remainder to D. The quotient truncates toward zero and the remainder carries the sign of the dividend.
- R2: With op = 1 (unsigned double-width divide), the unsigned value {Y, D} (Y upper) is divided by unsigned X. The low W bits of the quotient go to Y and the remainder to D.
- R3: With op = 2 (signed double-width divide), the signed value {Y, D} is divided by signed X. The quotient truncates toward zero and the remainder carries the dividend's sign. The low W bits of the quotient go to Y and the remainder to D.
- R4: With op = 3 (signed multiply), signed D is multiplied by signed Y. The upper W product bits go to Y and the lower W bits to D.
- R5: For any divide with X = 0, all register write enables stay low, flagsWe = 4'b0001 and flags[0] (C) = 1.
- R6: For a divide with nonzero X, flagsWe = 4'b1111 and C = 0. N (flags[3]) is bit W-1 of the written quotient. Z (flags[2]) is set when the full quotient is zero.
- R7: For op = 1, V (flags[1]) is set exactly when the quotient needs more than W bits.
- R8: For op = 0 and op = 2, V is set exactly when the true quotient lies outside -2^(W-1) .. 2^(W-1)-1.
- R9: For op = 3, flagsWe = 4'b1101 (V untouched). Z is set for a zero product, N is product bit 2W-1 and C is product bit W-1.
- R10: done is a one-cycle pulse. It rises W+1 clock edges after the edge that accepts start for op 0 and op 3, and 2W+1 edges after it for op 1 and op 2.
- R11: A start strobe while an operation is in progress is ignored. The running result and its timing are unchanged, and no second done follows.
- R12: During and after reset, done and all write enables are low.
- R13: Write enables are high only in the done cycle. A nonzero divide with op 0 writes D and X. Op 1, op 2 and op 3 write Y and D.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| op | input | 2 | 0 signed div, 1 unsigned wide div, 2 signed wide div, 3 signed multiply |
| dIn | input | W | Current D register |
| xIn | input | W | Current X register |
| yIn | input | W | Current Y register |
| dOut | output | W | New D value |
| xOut | output | W | New X value |
| yOut | output | W | New Y value |
| dWe | output | 1 | Write enable for D |
| xWe | output | 1 | Write enable for X |
| yWe | output | 1 | Write enable for Y |
| flags | output | 4 | {N, Z, V, C} |
| flagsWe | output | 4 | Per-flag update mask, same bit order |
| done | output | 1 | Result valid strobe |

## Verification
The hardest corners to reach from the ports are the signed overflow edges. The most negative dividend over minus one gives a quotient magnitude of exactly 2^(W-1), or 2^(2W-1) in the wide case, which a truncated result cannot tell from a legal value. A second hard corner is the unsigned wide divide whose quotient just exceeds W bits. The bench instantiates the unit at W = 4, which makes these cases part of a dense sweep: every operand pair for the single-width operations, and every divisor against a stride-3 walk of all double-width dividends. An in-flight start is injected mid-operation with different operands and opcode to show that it leaves the result and the done timing unchanged.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  typedef enum logic [1:0] {
    OP_DIVS  = 2'd0,
    OP_DIVUW = 2'd1,
    OP_DIVSW = 2'd2,
    OP_MULS  = 2'd3
  } mdOp_e;

  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } mdCtl_t;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_V = 1;
  localparam int FLAG_C = 0;

endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] op,
  output mdCtl_t     ctl
);
  localparam int W2 = 2 * W;
  localparam int CW = $clog2(W2);

  typedef enum logic [1:0] { S_IDLE, S_RUN, S_FIN } state_e;

  state_e state;
  logic [CW-1:0] stepsLeft;
  logic wideOp;

  assign wideOp = (op == OP_DIVUW) || (op == OP_DIVSW);

  always_comb begin
    ctl.load   = (state == S_IDLE) && start;
    ctl.step   = (state == S_RUN);
    ctl.finish = (state == S_FIN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      stepsLeft <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state     <= S_RUN;
          stepsLeft <= wideOp ? CW'(W2 - 1) : CW'(W - 1);
        end
        S_RUN: begin
          if (stepsLeft == '0) state <= S_FIN;
          else stepsLeft <= stepsLeft - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/muldiv_dp.sv
module muldiv_dp
  import muldiv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  mdCtl_t       ctl,
  input  logic [1:0]   op,
  input  logic [W-1:0] dIn,
  input  logic [W-1:0] xIn,
  input  logic [W-1:0] yIn,
  output logic [W-1:0] dOut,
  output logic [W-1:0] xOut,
  output logic [W-1:0] yOut,
  output logic         dWe,
  output logic         xWe,
  output logic         yWe,
  output logic [3:0]   flags,
  output logic [3:0]   flagsWe,
  output logic         done
);
  localparam int W2 = 2 * W;
  localparam logic [W2-1:0] ONE2   = W2'(1);
  localparam logic [W-1:0]  ONE1   = W'(1);
  localparam logic [W2-1:0] POSMAX = (ONE2 << (W - 1)) - ONE2;
  localparam logic [W2-1:0] NEGMAX = ONE2 << (W - 1);

  function automatic logic [W-1:0] magW(input logic [W-1:0] v);
    return v[W-1] ? (~v + ONE1) : v;
  endfunction

  function automatic logic [W2-1:0] magW2(input logic [W2-1:0] v);
    return v[W2-1] ? (~v + ONE2) : v;
  endfunction

  mdOp_e opR;
  logic negQ, negR, zeroDiv;
  logic [W-1:0]  divisor, rem;
  logic [W2-1:0] acc;

  // operand preparation
  mdOp_e opIn;
  logic [W2-1:0] ldAcc;
  logic [W-1:0]  ldDiv;
  logic ldNegQ, ldNegR, ldZero;

  assign opIn = mdOp_e'(op);

  always_comb begin
    ldAcc  = '0;
    ldDiv  = '0;
    ldNegQ = 1'b0;
    ldNegR = 1'b0;
    ldZero = (xIn == '0);
    case (opIn)
      OP_DIVS: begin
        ldAcc  = {magW(dIn), {W{1'b0}}};
        ldDiv  = magW(xIn);
        ldNegQ = dIn[W-1] ^ xIn[W-1];
        ldNegR = dIn[W-1];
      end
      OP_DIVUW: begin
        ldAcc = {yIn, dIn};
        ldDiv = xIn;
      end
      OP_DIVSW: begin
        ldAcc  = magW2({yIn, dIn});
        ldDiv  = magW(xIn);
        ldNegQ = yIn[W-1] ^ xIn[W-1];
        ldNegR = yIn[W-1];
      end
      default: begin
        ldAcc  = {{W{1'b0}}, magW(dIn)};
        ldDiv  = magW(yIn);
        ldNegQ = dIn[W-1] ^ yIn[W-1];
        ldZero = 1'b0;
      end
    endcase
  end

  // one iteration
  logic [W:0]    trial, addSum;
  logic          fits;
  logic [W-1:0]  nextRem;
  logic [W2-1:0] nextAcc;

  always_comb begin
    trial   = {rem, acc[W2-1]};
    fits    = trial >= {1'b0, divisor};
    addSum  = {1'b0, acc[W2-1:W]} + (acc[0] ? {1'b0, divisor} : '0);
    nextRem = rem;
    if (opR == OP_MULS) begin
      nextAcc = {addSum, acc[W-1:1]};
    end else begin
      nextAcc = {acc[W2-2:0], fits};
      nextRem = fits ? W'(trial - {1'b0, divisor}) : trial[W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opR     <= OP_DIVS;
      negQ    <= 1'b0;
      negR    <= 1'b0;
      zeroDiv <= 1'b0;
      divisor <= '0;
      rem     <= '0;
      acc     <= '0;
    end else if (ctl.load) begin
      opR     <= opIn;
      negQ    <= ldNegQ;
      negR    <= ldNegR;
      zeroDiv <= ldZero;
      divisor <= ldDiv;
      rem     <= '0;
      acc     <= ldAcc;
    end else if (ctl.step) begin
      rem <= nextRem;
      acc <= nextAcc;
    end
  end

  // sign restore and flags
  logic [W2-1:0] mag, sVal;
  logic [W-1:0]  rVal;
  logic          ovf;

  always_comb begin
    mag  = (opR == OP_DIVS) ? {{W{1'b0}}, acc[W-1:0]} : acc;
    sVal = negQ ? (~mag + ONE2) : mag;
    rVal = negR ? (~rem + ONE1) : rem;
    if (opR == OP_DIVUW) ovf = (mag[W2-1:W] != '0);
    else                 ovf = negQ ? (mag > NEGMAX) : (mag > POSMAX);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dOut <= '0; xOut <= '0; yOut <= '0;
      dWe <= 1'b0; xWe <= 1'b0; yWe <= 1'b0;
      flags <= '0; flagsWe <= '0; done <= 1'b0;
    end else begin
      done <= ctl.finish;
      dWe <= 1'b0; xWe <= 1'b0; yWe <= 1'b0;
      flagsWe <= '0;
      if (ctl.finish) begin
        if (opR == OP_MULS) begin
          yOut <= sVal[W2-1:W];
          dOut <= sVal[W-1:0];
          yWe  <= 1'b1;
          dWe  <= 1'b1;
          flags   <= {sVal[W2-1], mag == '0, 1'b0, sVal[W-1]};
          flagsWe <= 4'b1101;
        end else if (zeroDiv) begin
          flags   <= 4'b0001;
          flagsWe <= 4'b0001;
        end else begin
          dOut <= rVal;
          dWe  <= 1'b1;
          if (opR == OP_DIVS) begin
            xOut <= sVal[W-1:0];
            xWe  <= 1'b1;
          end else begin
            yOut <= sVal[W-1:0];
            yWe  <= 1'b1;
          end
          flags   <= {sVal[W-1], mag == '0, ovf, 1'b0};
          flagsWe <= 4'b1111;
        end
      end
    end
  end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] dIn,
  input  logic [W-1:0] xIn,
  input  logic [W-1:0] yIn,
  output logic [W-1:0] dOut,
  output logic [W-1:0] xOut,
  output logic [W-1:0] yOut,
  output logic         dWe,
  output logic         xWe,
  output logic         yWe,
  output logic [3:0]   flags,
  output logic [3:0]   flagsWe,
  output logic         done
);
  mdCtl_t ctl;

  muldiv_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .op(op), .ctl(ctl)
  );

  muldiv_dp #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .op(op),
    .dIn(dIn), .xIn(xIn), .yIn(yIn),
    .dOut(dOut), .xOut(xOut), .yOut(yOut),
    .dWe(dWe), .xWe(xWe), .yWe(yWe),
    .flags(flags), .flagsWe(flagsWe), .done(done)
  );
endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk
  import muldiv_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input mdCtl_t       ctl,
  input logic [1:0]   op,
  input logic [W-1:0] xIn,
  input logic         dWe,
  input logic         xWe,
  input logic         yWe,
  input logic [3:0]   flags,
  input logic [3:0]   flagsWe,
  input logic         done
);
  localparam int CNTW = $clog2(2 * W + 4) + 1;

  logic [1:0] savedOp;
  logic savedZero, inFlight;
  logic [CNTW-1:0] cyc;
  logic [CNTW-1:0] expLat;

  assign expLat = ((savedOp == OP_DIVUW) || (savedOp == OP_DIVSW)) ?
                  CNTW'(2 * W + 1) : CNTW'(W + 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      savedOp <= '0; savedZero <= 1'b0; inFlight <= 1'b0; cyc <= '0;
    end else if (ctl.load) begin
      savedOp   <= op;
      savedZero <= (op != OP_MULS) && (xIn == '0);
      inFlight  <= 1'b1;
      cyc       <= '0;
    end else if (done) begin
      inFlight <= 1'b0;
    end else if (inFlight) begin
      cyc <= cyc + 1'b1;
    end
  end

  p_we_in_done_r13: assert property (@(posedge clk) disable iff (!rstN)
    (dWe || xWe || yWe || (flagsWe != 4'b0)) |-> done);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_latency_r10: assert property (@(posedge clk) disable iff (!rstN)
    (done && inFlight) |-> (cyc == expLat));

  p_zero_div_r5: assert property (@(posedge clk) disable iff (!rstN)
    (done && savedZero) |-> (flags[FLAG_C] && flagsWe == 4'b0001 && !dWe && !xWe && !yWe));

  p_mul_keep_v_r9: assert property (@(posedge clk) disable iff (!rstN)
    (done && savedOp == OP_MULS) |-> (!flagsWe[FLAG_V] && dWe && yWe && !xWe));

  p_single_job_r11: assert property (@(posedge clk) disable iff (!rstN)
    (inFlight && !done) |-> !ctl.load);

  p_reset_quiet_r12: assert property (@(posedge clk)
    !rstN |=> (!done && !dWe && !xWe && !yWe));
endmodule

bind muldiv_unit muldiv_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rstN(rstN), .ctl(ctl), .op(op), .xIn(xIn),
  .dWe(dWe), .xWe(xWe), .yWe(yWe),
  .flags(flags), .flagsWe(flagsWe), .done(done)
);

// File: tb/muldiv_unit_test.sv
`timescale 1ns/1ps
module muldiv_unit_test;
  localparam int TW = 4;
  localparam longint M1 = 64'd1 << TW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [1:0] op = 2'd0;
  logic [TW-1:0] dIn = '0, xIn = '0, yIn = '0;
  logic [TW-1:0] dOut, xOut, yOut;
  logic dWe, xWe, yWe, done;
  logic [3:0] flags, flagsWe;

  int nTests = 0;
  int nFail = 0;

  always #2 clk = ~clk;

  muldiv_unit #(.W(TW)) uut (
    .clk(clk), .rstN(rstN), .start(start), .op(op),
    .dIn(dIn), .xIn(xIn), .yIn(yIn),
    .dOut(dOut), .xOut(xOut), .yOut(yOut),
    .dWe(dWe), .xWe(xWe), .yWe(yWe),
    .flags(flags), .flagsWe(flagsWe), .done(done)
  );

  function automatic longint sx(input longint v, input int bits);
    return (v >= (64'sd1 <<< (bits - 1))) ? v - (64'sd1 <<< bits) : v;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic runOp(input int o, input longint d, input longint x, input longint y, input bit poke);
    longint q, r, p, dd, dv, lo, hi;
    bit zero, v, n, z, c;
    logic [3:0] eWe, eFl;
    bit edW, exW, eyW;
    logic [TW-1:0] ed, ex, ey;
    int lat, expLat;
    string tag;
    longint act, exp;
    ed = '0; ex = '0; ey = '0; c = 1'b0; v = 1'b0; n = 1'b0; z = 1'b0;
    zero = (o != 3) && (x == 0);
    edW = 0; exW = 0; eyW = 0;
    case (o)
      0: tag = "R1";
      1: tag = "R2";
      2: tag = "R3";
      default: tag = "R4";
    endcase
    if (o == 3) begin
      p  = sx(d, TW) * sx(y, TW);
      lo = p & (M1 - 1);
      hi = (p >>> TW) & (M1 - 1);
      ed = TW'(lo); ey = TW'(hi); edW = 1; eyW = 1;
      z = (p == 0); n = p[2*TW-1]; c = p[TW-1];
      eWe = 4'b1101; tag = "R4/R9";
    end else if (zero) begin
      eWe = 4'b0001; c = 1'b1; tag = {tag, "/R5"};
    end else begin
      if (o == 0) begin dd = sx(d, TW); dv = sx(x, TW); end
      else if (o == 1) begin dd = y * M1 + d; dv = x; end
      else begin dd = sx(y * M1 + d, 2 * TW); dv = sx(x, TW); end
      q = dd / dv;
      r = dd % dv;
      if (o == 1) v = (q >= M1);
      else v = (q > (M1 / 2 - 1)) || (q < -(M1 / 2));
      ed = TW'(r & (M1 - 1)); edW = 1;
      if (o == 0) begin ex = TW'(q & (M1 - 1)); exW = 1; end
      else begin ey = TW'(q & (M1 - 1)); eyW = 1; end
      z = (q == 0); n = q[TW-1];
      eWe = 4'b1111; tag = {tag, (o == 1) ? "/R6/R7" : "/R6/R8"};
    end
    eFl = {n, z, v, c};
    expLat = ((o == 1) || (o == 2)) ? 2 * TW + 1 : TW + 1;

    @(negedge clk);
    op = 2'(o); dIn = TW'(d); xIn = TW'(x); yIn = TW'(y); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (poke && lat == 2) begin
        start = 1'b1; op = 2'd3; dIn = ~dIn; xIn = ~xIn; yIn = ~yIn;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    // R10 latency
    check(lat == expLat, poke ? "R11 latency" : "R10 latency", lat, expLat);
    // R13 enables, data and flags (don't-care fields take the actual value)
    act = {dOut, xOut, yOut, flags & flagsWe, flagsWe, dWe, xWe, yWe};
    exp = {edW ? ed : dOut, exW ? ex : xOut, eyW ? ey : yOut,
           eFl & eWe, eWe, edW, exW, eyW};
    check(act == exp, poke ? "R11 result" : tag, act, exp);
    @(posedge clk);
    @(negedge clk);
    check(!done, "R10 pulse", done, 0);
    if (poke) begin
      for (int i = 0; i < 3 * TW; i++) begin
        @(negedge clk);
        check(!done, "R11 no second done", done, 0);
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 quiet during reset
    check(!done && !dWe && !xWe && !yWe, "R12 in reset", {done, dWe, xWe, yWe}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!done && !dWe && !xWe && !yWe, "R12 after reset", {done, dWe, xWe, yWe}, 0);

    // R1 R5 R6 R8: all single-width signed divides
    for (int d = 0; d < M1; d++)
      for (int x = 0; x < M1; x++)
        runOp(0, d, x, 0, 1'b0);
    // R4 R9: all single-width multiplies
    for (int d = 0; d < M1; d++)
      for (int y = 0; y < M1; y++)
        runOp(3, d, 0, y, 1'b0);
    // R2 R3 R7 R8: every divisor against a stride-3 dividend walk
    for (int w = 0; w < M1 * M1; w += 3)
      for (int x = 0; x < M1; x++) begin
        runOp(1, w % M1, x, w / M1, 1'b0);
        runOp(2, w % M1, x, w / M1, 1'b0);
      end
    // corner values: most negative over minus one
    runOp(0, M1 / 2, M1 - 1, 0, 1'b0);
    runOp(2, 0, M1 - 1, M1 / 2, 1'b0);
    runOp(1, M1 - 1, 1, M1 - 1, 1'b0);
    // R11: start while busy
    runOp(1, 5, 3, 2, 1'b1);
    runOp(3, M1 / 2, 0, M1 / 2, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule